// File: doc/BRIEF.md
# Multiboot Image Selector with Fallback

This block sequences the boot of a configurable device from a byte-addressed serial flash. After power-on reset it always fetches the golden image from byte address zero. Once an image has loaded, the running design can store a warm-boot start address and then raise a one-cycle reprogram pulse, which makes the block fetch the image at that stored address.

Each image is parsed as it streams in. The block looks for the 32-bit sync word byte by byte, then checks a 32-bit device identifier, reads a 32-bit payload length, runs a CRC-32 over the payload and compares the result with a trailing 32-bit check value. Several faults abort the load: no sync word, a wrong identifier, a CRC mismatch, or a flash that stops answering. If the aborted image is an update and no fallback has happened since reset, the block goes back to the golden image. Any other failure parks the block in a halted error state.

A status register keeps the start address of the most recent load attempt, a sticky fallback flag and the cause of the most recent failure. Only the power-on reset clears it.

Top module: `boot_image_sel`

## Requirements
- R1: During and right after reset the block requests flash data (`rd_req` high) at byte address 0. `act_valid`, `act_update`, `boot_err`, `stat_fallback`, `stat_cause` and `stat_last_addr` are all zero.
- R2: A byte is taken in a cycle where `rd_req` and `rd_valid` are both high. `rd_addr` steps up by one for each byte taken and holds while `rd_valid` is low. A successful image therefore consumes exactly pad + 12 + length + 4 bytes.
- R3: The sync word 0xAA995566 is matched most significant byte first, at any byte alignment. The final byte of the match must lie within the first `SYNC_WIN` (256) bytes of the image, meaning offset 252 is the last accepted start. If no match is found the load fails with cause 1.
- R4: The four bytes after the sync word form the device identifier, most significant byte first. If it differs from `DEVICE_ID` the load fails with cause 2.
- R5: Next come a 32-bit payload length (most significant byte first, zero allowed), the payload, and a 32-bit check value (most significant byte first). The check value equals CRC-32 over the payload: reflected polynomial 0xEDB88320, initial value all ones, final inversion. A mismatch fails the load with cause 3.
- R6: If `rd_req` stays high with `rd_valid` low for `TIMEOUT_CYC` consecutive cycles, the load fails with cause 4.
- R7: A load that passes all checks raises `act_valid` and drops `rd_req`. `act_update` is 1 when the running image was started by a reprogram pulse and 0 for the golden image.
- R8: A write on `wb_wr_en` stores `wb_wr_data` as the warm-boot address. A `reprog_pulse` while `act_valid` is high starts a load at that address and sets `stat_last_addr` to it. A pulse at any other time is ignored.
- R9: A failed update load, when no fallback has occurred since reset, sets `stat_fallback` and restarts the fetch of the golden image at address 0.
- R10: A failure of the golden image, or of an update after a fallback has already occurred, raises `boot_err`. From then on `rd_req` and `act_valid` stay low and `boot_err` stays high until reset.
- R11: `stat_cause` holds the most recent failure cause (0 none, 1 sync, 2 identifier, 3 CRC, 4 timeout) and is not cleared by a later successful load. `stat_fallback` is sticky. Only reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| rd_req | output | 1 | Flash read request for the byte at `rd_addr` |
| rd_addr | output | ADDR_W | Flash byte address |
| rd_valid | input | 1 | Flash returns `rd_data` for the current address this cycle |
| rd_data | input | 8 | Flash data byte |
| reprog_pulse | input | 1 | Reprogram request from the running image |
| wb_wr_en | input | 1 | Write strobe for the warm-boot address |
| wb_wr_data | input | ADDR_W | Warm-boot start address |
| act_valid | output | 1 | An image has loaded and is running |
| act_update | output | 1 | Running image was loaded from the warm-boot address |
| boot_err | output | 1 | Halted after an unrecoverable load failure |
| stat_last_addr | output | ADDR_W | Start address of the most recent load attempt |
| stat_fallback | output | 1 | A fallback to the golden image has occurred |
| stat_cause | output | 3 | Cause of the most recent failure |

## Verification
Some properties are checked by assertions on every cycle. The address steps by one per accepted byte and holds under stall. The halted state and the fallback flag are sticky, and the block is silent once halted. A fallback always restarts at address zero. A running image issues no requests, and a reprogram pulse redirects the fetch to the recorded start address. Other behaviour only the directed scenarios can show: which cause a given image defect produces, the exact sync search window edge, CRC and identifier acceptance, the timeout, that a second failure halts instead of falling back again, and that a later successful update leaves the recorded cause in place.

// File: rtl/boot_pkg.sv
package boot_pkg;

    localparam logic [31:0] SYNC_WORD = 32'hAA99_5566;
    localparam logic [31:0] CRC_POLY  = 32'hEDB8_8320;

    typedef enum logic [2:0] {
        ST_SYNC = 3'd0,
        ST_ID   = 3'd1,
        ST_LEN  = 3'd2,
        ST_PAY  = 3'd3,
        ST_CRC  = 3'd4,
        ST_RUN  = 3'd5,
        ST_HALT = 3'd6
    } boot_st_e;

    typedef enum logic [2:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_SYNC = 3'd1,
        CAUSE_ID   = 3'd2,
        CAUSE_CRC  = 3'd3,
        CAUSE_TMO  = 3'd4
    } boot_cause_e;

endpackage

// File: rtl/boot_crc32_step.sv
module boot_crc32_step
    import boot_pkg::*;
(
    input  logic [31:0] crc_in,
    input  logic [7:0]  data_in,
    output logic [31:0] crc_out
);
    logic [31:0] c;

    always_comb begin
        c = crc_in ^ {24'h0, data_in};
        for (int i = 0; i < 8; i++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
        end
        crc_out = c;
    end
endmodule

// File: rtl/boot_sync_win.sv
module boot_sync_win
    import boot_pkg::*;
(
    input  logic [31:0] win_in,
    input  logic [7:0]  data_in,
    output logic [31:0] win_out,
    output logic        hit
);
    always_comb begin
        win_out = {win_in[23:0], data_in};
        hit     = (win_out == SYNC_WORD);
    end
endmodule

// File: rtl/boot_wdog.sv
module boot_wdog #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic waiting,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expired = waiting && (cnt_q == CW'(LIMIT - 1));
        if (!waiting || expired) cnt_d = '0;
        else                     cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/boot_image_sel.sv
module boot_image_sel
    import boot_pkg::*;
#(
    parameter int          ADDR_W      = 24,
    parameter logic [31:0] DEVICE_ID   = 32'h1C0D_E5A7,
    parameter int          SYNC_WIN    = 256,
    parameter int          TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [7:0]        rd_data,
    input  logic              reprog_pulse,
    input  logic              wb_wr_en,
    input  logic [ADDR_W-1:0] wb_wr_data,
    output logic              act_valid,
    output logic              act_update,
    output logic              boot_err,
    output logic [ADDR_W-1:0] stat_last_addr,
    output logic              stat_fallback,
    output logic [2:0]        stat_cause
);
    localparam int WIN_CW = $clog2(SYNC_WIN);

    typedef struct packed {
        boot_st_e          st;
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] wb;
        logic [ADDR_W-1:0] last;
        logic              upd;
        logic              fb;
        boot_cause_e       cause;
        logic [WIN_CW-1:0] scnt;
        logic [1:0]        fcnt;
        logic [31:0]       win;
        logic [31:0]       fld;
        logic [31:0]       len;
        logic [31:0]       crc;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st: ST_SYNC, ptr: '0, wb: '0, last: '0, upd: 1'b0, fb: 1'b0,
        cause: CAUSE_NONE, scnt: '0, fcnt: '0, win: '0, fld: '0,
        len: '0, crc: 32'hFFFF_FFFF
    };

    regs_t r_d, r_q;

    logic        reading;
    logic        take;
    logic        tmo;
    logic        hit;
    logic [31:0] win_nx;
    logic [31:0] crc_nx;
    logic [31:0] fld_sh;
    logic        fail;
    boot_cause_e fcause;

    function automatic regs_t restart(input regs_t r, input logic [ADDR_W-1:0] a);
        regs_t n;
        n      = r;
        n.st   = ST_SYNC;
        n.ptr  = a;
        n.last = a;
        n.scnt = '0;
        n.fcnt = '0;
        n.win  = '0;
        n.fld  = '0;
        n.len  = '0;
        n.crc  = 32'hFFFF_FFFF;
        return n;
    endfunction

    assign reading = (r_q.st == ST_SYNC) || (r_q.st == ST_ID) || (r_q.st == ST_LEN) ||
                     (r_q.st == ST_PAY)  || (r_q.st == ST_CRC);
    assign take    = reading && rd_valid;
    assign fld_sh  = {r_q.fld[23:0], rd_data};

    boot_sync_win u_sync (
        .win_in  (r_q.win),
        .data_in (rd_data),
        .win_out (win_nx),
        .hit     (hit)
    );

    boot_crc32_step u_crc (
        .crc_in  (r_q.crc),
        .data_in (rd_data),
        .crc_out (crc_nx)
    );

    boot_wdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .waiting (reading && !rd_valid),
        .expired (tmo)
    );

    always_comb begin
        r_d    = r_q;
        fail   = 1'b0;
        fcause = CAUSE_NONE;

        if (wb_wr_en) r_d.wb = wb_wr_data;
        if (take)     r_d.ptr = r_q.ptr + ADDR_W'(1);

        case (r_q.st)
            ST_SYNC: begin
                if (take) begin
                    r_d.win = win_nx;
                    if (hit) begin
                        r_d.st   = ST_ID;
                        r_d.fcnt = '0;
                    end else if (r_q.scnt == WIN_CW'(SYNC_WIN - 1)) begin
                        fail   = 1'b1;
                        fcause = CAUSE_SYNC;
                    end else begin
                        r_d.scnt = r_q.scnt + WIN_CW'(1);
                    end
                end
            end
            ST_ID: begin
                if (take) begin
                    r_d.fld  = fld_sh;
                    r_d.fcnt = r_q.fcnt + 2'd1;
                    if (r_q.fcnt == 2'd3) begin
                        if (fld_sh != DEVICE_ID) begin
                            fail   = 1'b1;
                            fcause = CAUSE_ID;
                        end else begin
                            r_d.st = ST_LEN;
                        end
                    end
                end
            end
            ST_LEN: begin
                if (take) begin
                    r_d.fld  = fld_sh;
                    r_d.fcnt = r_q.fcnt + 2'd1;
                    if (r_q.fcnt == 2'd3) begin
                        r_d.len = fld_sh;
                        r_d.st  = (fld_sh == 32'd0) ? ST_CRC : ST_PAY;
                    end
                end
            end
            ST_PAY: begin
                if (take) begin
                    r_d.crc = crc_nx;
                    r_d.len = r_q.len - 32'd1;
                    if (r_q.len == 32'd1) r_d.st = ST_CRC;
                end
            end
            ST_CRC: begin
                if (take) begin
                    r_d.fld  = fld_sh;
                    r_d.fcnt = r_q.fcnt + 2'd1;
                    if (r_q.fcnt == 2'd3) begin
                        if (fld_sh == ~r_q.crc) begin
                            r_d.st = ST_RUN;
                        end else begin
                            fail   = 1'b1;
                            fcause = CAUSE_CRC;
                        end
                    end
                end
            end
            ST_RUN: begin
                if (reprog_pulse) begin
                    r_d     = restart(r_d, r_q.wb);
                    r_d.upd = 1'b1;
                end
            end
            default: begin
                r_d.st = ST_HALT;
            end
        endcase

        if (reading && tmo) begin
            fail   = 1'b1;
            fcause = CAUSE_TMO;
        end

        if (fail) begin
            r_d.cause = fcause;
            if (r_q.upd && !r_q.fb) begin
                r_d     = restart(r_d, '0);
                r_d.fb  = 1'b1;
                r_d.upd = 1'b0;
            end else begin
                r_d.st = ST_HALT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign rd_req         = reading;
    assign rd_addr        = r_q.ptr;
    assign act_valid      = (r_q.st == ST_RUN);
    assign act_update     = (r_q.st == ST_RUN) && r_q.upd;
    assign boot_err       = (r_q.st == ST_HALT);
    assign stat_last_addr = r_q.last;
    assign stat_fallback  = r_q.fb;
    assign stat_cause     = r_q.cause;

endmodule

// File: rtl/boot_image_sel_chk.sv
module boot_image_sel_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_valid,
    input logic              reprog_pulse,
    input logic              act_valid,
    input logic              act_update,
    input logic              boot_err,
    input logic [ADDR_W-1:0] stat_last_addr,
    input logic              stat_fallback,
    input logic [2:0]        stat_cause
);
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_valid) |=> (!rd_req || rd_addr == $past(rd_addr) + ADDR_W'(1) ||
                                  rd_addr == stat_last_addr)); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (!rd_req || rd_addr == $past(rd_addr) ||
                                   rd_addr == stat_last_addr)); // R2
    AST_RUN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> !rd_req); // R7
    AST_UPD_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        act_update |-> act_valid); // R7
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && reprog_pulse) |=> (rd_req && !act_valid && rd_addr == stat_last_addr)); // R8
    AST_FB_TO_GOLDEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_fallback) |-> (rd_req && rd_addr == '0 && stat_last_addr == '0)); // R9
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        boot_err |=> boot_err); // R10
    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        boot_err |-> (!rd_req && !act_valid)); // R10
    AST_HALT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        boot_err |-> (stat_cause != 3'd0)); // R10
    AST_FB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stat_fallback |=> stat_fallback); // R11
endmodule

bind boot_image_sel boot_image_sel_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/boot_image_sel_tb.sv
module boot_image_sel_tb_top;
    localparam int          AW    = 24;
    localparam logic [31:0] DEVID = 32'h1C0D_E5A7;
    localparam logic [AW-1:0] UBASE = 24'h40_0000;
    localparam int          RSZ   = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_req, rd_valid = 1'b0;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data = 8'h00;
    logic          reprog_pulse = 1'b0, wb_wr_en = 1'b0;
    logic [AW-1:0] wb_wr_data = '0;
    logic          act_valid, act_update, boot_err, stat_fallback;
    logic [AW-1:0] stat_last_addr;
    logic [2:0]    stat_cause;

    int  n_chk = 0, n_err = 0, cyc = 0, acc_cnt = 0;
    bit  stall_en = 1'b0, dead_upd = 1'b0;
    logic [7:0] gmem [RSZ];
    logic [7:0] umem [RSZ];

    always #4 clk = ~clk;

    boot_image_sel dut_i (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .reprog_pulse(reprog_pulse),
        .wb_wr_en(wb_wr_en), .wb_wr_data(wb_wr_data), .act_valid(act_valid),
        .act_update(act_update), .boot_err(boot_err), .stat_last_addr(stat_last_addr),
        .stat_fallback(stat_fallback), .stat_cause(stat_cause)
    );

    function automatic logic [7:0] fbyte(input logic [AW-1:0] a);
        if (a < AW'(RSZ)) return gmem[a];
        if (a >= UBASE && a < UBASE + AW'(RSZ)) return umem[a - UBASE];
        return 8'hFF;
    endfunction

    // flash model: answers at the falling edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rd_req && !(stall_en && (cyc % 3 == 1)) && !(dead_upd && rd_addr >= UBASE)) begin
            rd_valid = 1'b1;
            rd_data  = fbyte(rd_addr);
        end else begin
            rd_valid = 1'b0;
            rd_data  = 8'h00;
        end
    end

    always @(posedge clk) if (rst_n && rd_req && rd_valid) acc_cnt = acc_cnt + 1;

    function automatic logic [31:0] crc_ref(input logic [7:0] buf_b [RSZ], input int off, input int len);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < len; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic fbk = c[0] ^ buf_b[off + i][b];
                c = {1'b0, c[31:1]};
                if (fbk) c = c ^ 32'hEDB8_8320;
            end
        end
        return ~c;
    endfunction

    task automatic build(input bit upd, input int pad, input logic [31:0] id,
                         input int len, input bit bad_crc, input bit no_sync);
        logic [7:0] m [RSZ];
        logic [31:0] w [4];
        logic [31:0] crc;
        int p;
        for (int i = 0; i < RSZ; i++) m[i] = 8'h00;
        if (!no_sync) begin
            for (int i = 0; i < len; i++) m[pad + 12 + i] = 8'((i * 7 + 3) ^ 8'h5A);
            crc = crc_ref(m, pad + 12, len) ^ (bad_crc ? 32'h0000_0100 : 32'h0);
            w[0] = 32'hAA99_5566; w[1] = id; w[2] = 32'(len); w[3] = crc;
            p = pad;
            for (int k = 0; k < 3; k++) begin
                for (int j = 3; j >= 0; j--) begin m[p] = w[k][8*j +: 8]; p++; end
            end
            p = pad + 12 + len;
            for (int j = 3; j >= 0; j--) begin m[p] = w[3][8*j +: 8]; p++; end
        end
        for (int i = 0; i < RSZ; i++) begin
            if (upd) umem[i] = m[i]; else gmem[i] = m[i];
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; stall_en = 1'b0; dead_upd = 1'b0;
        reprog_pulse = 1'b0; wb_wr_en = 1'b0;
        repeat (3) @(negedge clk);
        acc_cnt = 0;
        rst_n = 1'b1;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!act_valid && !boot_err && n < 20000) begin @(negedge clk); n++; end
        check({req, " load settles"}, 32'(act_valid || boot_err), 32'd1);
    endtask

    task automatic pulse_jump(input logic [AW-1:0] a);
        @(negedge clk); wb_wr_en = 1'b1; wb_wr_data = a;
        @(negedge clk); wb_wr_en = 1'b0; reprog_pulse = 1'b1;
        @(negedge clk); reprog_pulse = 1'b0;
    endtask

    task automatic expect_state(input string req, input bit av, input bit au, input bit er,
                                input bit fb, input logic [2:0] cs, input logic [AW-1:0] la);
        check({req, " act_valid"},  32'(act_valid), 32'(av));
        check({req, " act_update"}, 32'(act_update), 32'(au));
        check({req, " boot_err"},   32'(boot_err), 32'(er));
        check({req, " fallback"},   32'(stat_fallback), 32'(fb));
        check({req, " cause"},      32'(stat_cause), 32'(cs));
        check({req, " last_addr"},  32'(stat_last_addr), 32'(la));
    endtask

    // R1 reset state, R2 byte count, R7 golden run, R8 pulse ignored while loading
    task automatic t_golden();
        build(0, 7, DEVID, 33, 0, 0);
        @(negedge clk); rst_n = 1'b0; acc_cnt = 0;
        repeat (2) @(negedge clk);
        check("R1 rd_req in reset", 32'(rd_req), 32'd1);
        check("R1 rd_addr in reset", 32'(rd_addr), 32'd0);
        expect_state("R1 reset", 0, 0, 0, 0, 3'd0, '0);
        rst_n = 1'b1; stall_en = 1'b1;
        repeat (10) @(negedge clk);
        reprog_pulse = 1'b1; @(negedge clk); reprog_pulse = 1'b0;
        wait_done("R7 golden");
        expect_state("R8 pulse during load ignored / R7 golden", 1, 0, 0, 0, 3'd0, '0);
        check("R2 bytes consumed", 32'(acc_cnt), 32'(7 + 12 + 33 + 4));
        check("R7 no request while running", 32'(rd_req), 32'd0);
    endtask

    // R8 jump to update, R3 sync at last allowed offset
    task automatic t_update_ok();
        build(1, 252, DEVID, 40, 0, 0);
        acc_cnt = 0;
        pulse_jump(UBASE);
        wait_done("R8 update");
        expect_state("R8 update running / R3 offset 252", 1, 1, 0, 0, 3'd0, UBASE);
        check("R2 update bytes consumed", 32'(acc_cnt), 32'(252 + 12 + 40 + 4));
    endtask

    // R3 sync too late -> R9 fallback
    task automatic t_sync_late();
        do_reset(); build(0, 0, DEVID, 5, 0, 0);
        wait_done("R3 golden");
        build(1, 253, DEVID, 10, 0, 0);
        pulse_jump(UBASE);
        wait_done("R3 late sync");
        expect_state("R3 sync window / R9 fallback", 1, 0, 0, 1, 3'd1, '0);
    endtask

    // R4 id error, R11 cause kept after success, R10 second failure halts, R5 crc
    task automatic t_id_then_halt();
        do_reset(); build(0, 3, DEVID, 9, 0, 0);
        wait_done("R4 golden");
        build(1, 1, DEVID ^ 32'h1, 9, 0, 0);
        pulse_jump(UBASE);
        wait_done("R4 bad id");
        expect_state("R4 id mismatch / R9", 1, 0, 0, 1, 3'd2, '0);
        build(1, 2, DEVID, 17, 0, 0);
        pulse_jump(UBASE);
        wait_done("R11 good update");
        expect_state("R11 cause retained", 1, 1, 0, 1, 3'd2, UBASE);
        build(1, 2, DEVID, 17, 1, 0);
        pulse_jump(UBASE);
        wait_done("R10 second failure");
        expect_state("R10 halt / R5 crc cause", 0, 0, 1, 1, 3'd3, UBASE);
        repeat (40) @(negedge clk);
        check("R10 halt sticky", 32'(boot_err), 32'd1);
        check("R10 no requests", 32'(rd_req), 32'd0);
    endtask

    // R5 zero length golden, crc error on update
    task automatic t_crc();
        build(0, 0, DEVID, 0, 0, 0);
        do_reset();
        wait_done("R5 zero length");
        expect_state("R5 zero length golden", 1, 0, 0, 0, 3'd0, '0);
        build(1, 4, DEVID, 64, 1, 0);
        pulse_jump(UBASE);
        wait_done("R5 crc");
        expect_state("R5 crc mismatch / R9", 1, 0, 0, 1, 3'd3, '0);
    endtask

    // R6 timeout on update region
    task automatic t_timeout();
        build(0, 1, DEVID, 6, 0, 0);
        do_reset();
        wait_done("R6 golden");
        build(1, 0, DEVID, 6, 0, 0);
        dead_upd = 1'b1;
        pulse_jump(UBASE);
        wait_done("R6 timeout");
        expect_state("R6 timeout / R9", 1, 0, 0, 1, 3'd4, '0);
        dead_upd = 1'b0;
    endtask

    // R10 golden failure, R3 missing sync on golden
    task automatic t_golden_bad();
        build(0, 2, DEVID, 11, 1, 0);
        do_reset();
        wait_done("R10 golden crc");
        expect_state("R10 golden failure halts", 0, 0, 1, 0, 3'd3, '0);
        build(0, 0, DEVID, 0, 0, 1);
        do_reset();
        wait_done("R3 no sync");
        expect_state("R3 golden without sync", 0, 0, 1, 0, 3'd1, '0);
    endtask

    initial begin
        for (int i = 0; i < RSZ; i++) begin gmem[i] = 8'h00; umem[i] = 8'h00; end
        t_golden();
        t_update_ok();
        t_sync_late();
        t_id_then_halt();
        t_crc();
        t_timeout();
        t_golden_bad();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule